// File: doc/BRIEF.md
# Coherence Response Tracker

This block sits beside a cache controller and keeps one record for each of its outstanding misses. When a reply arrives from the coherence network, carrying either data or an invalidation acknowledgement, the block looks up the addressed record and names the reply with one of five event codes. The cache state machine acts on that code. Each record holds a signed count of acknowledgements still owed. Acknowledgements may overtake the data reply that announces how many to expect, so the count is allowed to go below zero. Completion is judged on the sum of the announced count and the stored count.

The controller claims a record when it issues a miss and gets the lowest free index back in the same cycle. While the miss is open, forwarded read requests add a requester to a set in the record, and a forwarded ownership request stores one requester and the ack count it needs. On the final event the record is reported on the completion outputs and freed. A reply that addresses a free record raises an error pulse and changes nothing.

Top module: `coh_resp_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `rsp_ready` is 0 and `evt`, `err` and `cmp_valid` are 0. All records start free, so the first allocation after reset is granted index 0.
- R2: `alloc_gnt` is high in the same cycle as `alloc_req` exactly when a record is free, and `alloc_idx` then gives the lowest free index. With every record busy, `alloc_gnt` stays 0.
- R3: A DATA reply (`rsp_kind`=0) whose `rsp_acks` is 0 raises `evt` bit 0 and completes the record.
- R4: A DATA reply with nonzero `rsp_acks`, where `rsp_acks` plus the stored count is nonzero, raises `evt` bit 1. The stored count becomes that sum and the record stays open.
- R5: A DATA reply with nonzero `rsp_acks`, where `rsp_acks` plus the stored count is zero, raises `evt` bit 2 and completes the record.
- R6: An ACK reply (`rsp_kind`=1) raises `evt` bit 4 and completes the record when the stored count is exactly 1. Otherwise it raises `evt` bit 3 and decrements the stored count, which may go negative.
- R7: On completion, `cmp_valid` pulses with `cmp_idx` and the record's prefetch flag and forward record, and the record is freed. A newly claimed record starts with a count of 0, the prefetch flag taken from `alloc_prefetch`, an empty requester set and no ownership forward.
- R8: `fwd_gets_valid` sets bit `fwd_gets_req` of the requester set of a busy record. `fwd_getx_valid` stores the requester ID and ack count and marks an ownership forward as present. Both are dropped for a free record.
- R9: A reply that addresses a free record pulses `err`, raises no event and no completion, and leaves every record unchanged.
- R10: A reply is accepted on a rising edge where `rsp_valid` and `rsp_ready` are both high, at most one per cycle. Its `evt`, `evt_idx`, `err` and completion outputs are registered and valid for the one cycle after that edge. `evt` is zero or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Claim a free record |
| alloc_prefetch | input | 1 | Prefetch flag for the claimed record |
| alloc_gnt | output | 1 | Claim granted this cycle |
| alloc_idx | output | IDX_W | Index of the granted record |
| rsp_valid | input | 1 | Reply present |
| rsp_ready | output | 1 | Block can take a reply |
| rsp_kind | input | 1 | 0 = DATA, 1 = ACK |
| rsp_acks | input | ACK_W | Ack count carried by DATA |
| rsp_idx | input | IDX_W | Record addressed by the reply |
| fwd_gets_valid | input | 1 | Record a forwarded read requester |
| fwd_gets_idx | input | IDX_W | Record for the read forward |
| fwd_gets_req | input | REQ_W | Read requester ID |
| fwd_getx_valid | input | 1 | Record a forwarded ownership requester |
| fwd_getx_idx | input | IDX_W | Record for the ownership forward |
| fwd_getx_req | input | REQ_W | Ownership requester ID |
| fwd_getx_acks | input | ACK_W | Ack count to pass with the ownership forward |
| evt | output | 5 | One-hot event of the last accepted reply |
| evt_idx | output | IDX_W | Record the event refers to |
| err | output | 1 | Reply addressed a free record |
| cmp_valid | output | 1 | Record completed and freed |
| cmp_idx | output | IDX_W | Completed record |
| cmp_prefetch | output | 1 | Prefetch flag of the completed record |
| cmp_gets_set | output | NUM_CACHES | Forwarded read requesters |
| cmp_getx_valid | output | 1 | An ownership forward was recorded |
| cmp_getx_req | output | REQ_W | Ownership requester ID |
| cmp_getx_acks | output | ACK_W | Ack count for the ownership forward |

## Verification
The allocation grant and index are combinational, so the bench reads them a short delay after driving `alloc_req` and before the next rising edge. The event, error and completion outputs come from one register stage. The bench drives a reply on a falling edge, lets one rising edge accept it, and compares those outputs on the following falling edge, where they hold the result of that single reply. A record's count has no output of its own. The bench follows it by sending later replies to the same record and checking which event each one produces, and it checks forward records on the completion outputs.

// File: rtl/coh_trk_pkg.sv
// Shared encodings for the coherence response tracker.
// Assumes: event bit positions are decoded by the consuming state machine.
package coh_trk_pkg;
    localparam int EVT_W        = 5;
    localparam int EV_DATA_ZERO = 0;
    localparam int EV_DATA_MORE = 1;
    localparam int EV_DATA_LAST = 2;
    localparam int EV_ACK       = 3;
    localparam int EV_ACK_LAST  = 4;

    typedef enum logic {
        RSP_DATA = 1'b0,
        RSP_ACK  = 1'b1
    } rsp_kind_e;
endpackage

// File: rtl/coh_trk_classify.sv
// Names one reply against the stored ack count of its record.
// Assumes: CNT_W > ACK_W so the carried count fits as a positive signed value.
module coh_trk_classify
    import coh_trk_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ACK_W = 4
) (
    input  rsp_kind_e                kind,
    input  logic [ACK_W-1:0]         carried,
    input  logic signed [CNT_W-1:0]  cnt,
    output logic [EVT_W-1:0]         evt,
    output logic signed [CNT_W-1:0]  cnt_nxt,
    output logic                     cnt_upd,
    output logic                     done
);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    logic signed [CNT_W-1:0] carried_s;
    logic signed [CNT_W-1:0] sum;

    assign carried_s = {{(CNT_W-ACK_W){1'b0}}, carried};
    assign sum       = cnt + carried_s;

    // Decide the event, the new count and whether the record finishes.
    always_comb begin
        evt     = '0;
        cnt_nxt = cnt;
        cnt_upd = 1'b0;
        done    = 1'b0;
        if (kind == RSP_ACK) begin
            if (cnt == ONE) begin
                evt[EV_ACK_LAST] = 1'b1;
                done             = 1'b1;
            end else begin
                evt[EV_ACK] = 1'b1;
                cnt_nxt     = cnt - ONE;
                cnt_upd     = 1'b1;
            end
        end else if (carried == '0) begin
            evt[EV_DATA_ZERO] = 1'b1;
            done              = 1'b1;
        end else if (sum == '0) begin
            evt[EV_DATA_LAST] = 1'b1;
            done              = 1'b1;
        end else begin
            evt[EV_DATA_MORE] = 1'b1;
            cnt_nxt           = sum;
            cnt_upd           = 1'b1;
        end
    end
endmodule

// File: rtl/coh_trk_pick.sv
// Finds the lowest-numbered free record.
// Assumes: free_vec bit i is high when record i may be claimed.
module coh_trk_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     free_vec,
    output logic             any_free,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest free index wins.
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/coh_trk_entry.sv
// Storage for one outstanding-miss record: busy bit, signed ack count,
// prefetch flag and deferred-forward record.
// Assumes: alloc_we only targets a free record; free_we only a busy one.
module coh_trk_entry #(
    parameter int CNT_W      = 5,
    parameter int ACK_W      = 4,
    parameter int NUM_CACHES = 8,
    parameter int REQ_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_we,
    input  logic                    alloc_pf,
    input  logic                    cnt_we,
    input  logic signed [CNT_W-1:0] cnt_in,
    input  logic                    free_we,
    input  logic                    gets_we,
    input  logic [REQ_W-1:0]        gets_req,
    input  logic                    getx_we,
    input  logic [REQ_W-1:0]        getx_req,
    input  logic [ACK_W-1:0]        getx_acks,
    output logic                    busy,
    output logic signed [CNT_W-1:0] cnt,
    output logic                    pf,
    output logic [NUM_CACHES-1:0]   gets_set,
    output logic                    gx_vld,
    output logic [REQ_W-1:0]        gx_req,
    output logic [ACK_W-1:0]        gx_acks
);
    // Claim, update or release the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            pf       <= 1'b0;
            gets_set <= '0;
            gx_vld   <= 1'b0;
            gx_req   <= '0;
            gx_acks  <= '0;
        end else if (alloc_we) begin
            busy     <= 1'b1;
            cnt      <= '0;
            pf       <= alloc_pf;
            gets_set <= '0;
            gx_vld   <= 1'b0;
            gx_req   <= '0;
            gx_acks  <= '0;
        end else if (free_we) begin
            busy <= 1'b0;
        end else begin
            if (cnt_we) begin
                cnt <= cnt_in;
            end
            if (gets_we) begin
                gets_set[gets_req] <= 1'b1;
            end
            if (getx_we) begin
                gx_vld  <= 1'b1;
                gx_req  <= getx_req;
                gx_acks <= getx_acks;
            end
        end
    end
endmodule

// File: rtl/coh_resp_tracker.sv
// Top of the coherence response tracker: record table, claim logic,
// reply classification and registered event/completion outputs.
// Assumes: replies are accepted one per cycle; forward records written in
// the cycle a record completes are dropped.
module coh_resp_tracker
    import coh_trk_pkg::*;
#(
    parameter  int NUM_ENTRIES = 4,
    parameter  int NUM_CACHES  = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int REQ_W = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
    localparam int ACK_W = $clog2(NUM_CACHES + 1),
    localparam int CNT_W = ACK_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_req,
    input  logic                  alloc_prefetch,
    output logic                  alloc_gnt,
    output logic [IDX_W-1:0]      alloc_idx,
    input  logic                  rsp_valid,
    output logic                  rsp_ready,
    input  logic                  rsp_kind,
    input  logic [ACK_W-1:0]      rsp_acks,
    input  logic [IDX_W-1:0]      rsp_idx,
    input  logic                  fwd_gets_valid,
    input  logic [IDX_W-1:0]      fwd_gets_idx,
    input  logic [REQ_W-1:0]      fwd_gets_req,
    input  logic                  fwd_getx_valid,
    input  logic [IDX_W-1:0]      fwd_getx_idx,
    input  logic [REQ_W-1:0]      fwd_getx_req,
    input  logic [ACK_W-1:0]      fwd_getx_acks,
    output logic [EVT_W-1:0]      evt,
    output logic [IDX_W-1:0]      evt_idx,
    output logic                  err,
    output logic                  cmp_valid,
    output logic [IDX_W-1:0]      cmp_idx,
    output logic                  cmp_prefetch,
    output logic [NUM_CACHES-1:0] cmp_gets_set,
    output logic                  cmp_getx_valid,
    output logic [REQ_W-1:0]      cmp_getx_req,
    output logic [ACK_W-1:0]      cmp_getx_acks
);
    logic                    ent_busy [NUM_ENTRIES];
    logic signed [CNT_W-1:0] ent_cnt  [NUM_ENTRIES];
    logic                    ent_pf   [NUM_ENTRIES];
    logic [NUM_CACHES-1:0]   ent_gets [NUM_ENTRIES];
    logic                    ent_gxv  [NUM_ENTRIES];
    logic [REQ_W-1:0]        ent_gxr  [NUM_ENTRIES];
    logic [ACK_W-1:0]        ent_gxa  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]  free_vec;

    logic                    ready_q;
    logic                    accept;
    logic                    hit;
    logic                    sel_busy;
    logic signed [CNT_W-1:0] sel_cnt;
    logic                    sel_pf;
    logic [NUM_CACHES-1:0]   sel_gets;
    logic                    sel_gxv;
    logic [REQ_W-1:0]        sel_gxr;
    logic [ACK_W-1:0]        sel_gxa;
    logic [EVT_W-1:0]        cls_evt;
    logic signed [CNT_W-1:0] cls_cnt;
    logic                    cls_upd;
    logic                    cls_done;
    logic                    pick_any;
    logic [IDX_W-1:0]        pick_idx;

    // Replies are taken from the first cycle after reset onward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign rsp_ready = ready_q;
    assign accept    = rsp_valid && ready_q;
    assign hit       = accept && sel_busy;

    coh_trk_pick #(
        .N     (NUM_ENTRIES),
        .IDX_W (IDX_W)
    ) pick_i (
        .free_vec (free_vec),
        .any_free (pick_any),
        .idx      (pick_idx)
    );

    assign alloc_gnt = alloc_req && pick_any;
    assign alloc_idx = pick_idx;

    // Select the record the reply addresses; out-of-range reads as free.
    always_comb begin
        sel_busy = 1'b0;
        sel_cnt  = '0;
        sel_pf   = 1'b0;
        sel_gets = '0;
        sel_gxv  = 1'b0;
        sel_gxr  = '0;
        sel_gxa  = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (rsp_idx == IDX_W'(i)) begin
                sel_busy = ent_busy[i];
                sel_cnt  = ent_cnt[i];
                sel_pf   = ent_pf[i];
                sel_gets = ent_gets[i];
                sel_gxv  = ent_gxv[i];
                sel_gxr  = ent_gxr[i];
                sel_gxa  = ent_gxa[i];
            end
        end
    end

    coh_trk_classify #(
        .CNT_W (CNT_W),
        .ACK_W (ACK_W)
    ) cls_i (
        .kind    (rsp_kind_e'(rsp_kind)),
        .carried (rsp_acks),
        .cnt     (sel_cnt),
        .evt     (cls_evt),
        .cnt_nxt (cls_cnt),
        .cnt_upd (cls_upd),
        .done    (cls_done)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic this_rsp;
        assign this_rsp    = hit && (rsp_idx == IDX_W'(g));
        assign free_vec[g] = !ent_busy[g];

        coh_trk_entry #(
            .CNT_W      (CNT_W),
            .ACK_W      (ACK_W),
            .NUM_CACHES (NUM_CACHES),
            .REQ_W      (REQ_W)
        ) ent_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_we  (alloc_gnt && (pick_idx == IDX_W'(g))),
            .alloc_pf  (alloc_prefetch),
            .cnt_we    (this_rsp && cls_upd),
            .cnt_in    (cls_cnt),
            .free_we   (this_rsp && cls_done),
            .gets_we   (fwd_gets_valid && (fwd_gets_idx == IDX_W'(g)) && ent_busy[g]),
            .gets_req  (fwd_gets_req),
            .getx_we   (fwd_getx_valid && (fwd_getx_idx == IDX_W'(g)) && ent_busy[g]),
            .getx_req  (fwd_getx_req),
            .getx_acks (fwd_getx_acks),
            .busy      (ent_busy[g]),
            .cnt       (ent_cnt[g]),
            .pf        (ent_pf[g]),
            .gets_set  (ent_gets[g]),
            .gx_vld    (ent_gxv[g]),
            .gx_req    (ent_gxr[g]),
            .gx_acks   (ent_gxa[g])
        );
    end

    // Register the event, error and completion report of the accepted reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt            <= '0;
            evt_idx        <= '0;
            err            <= 1'b0;
            cmp_valid      <= 1'b0;
            cmp_idx        <= '0;
            cmp_prefetch   <= 1'b0;
            cmp_gets_set   <= '0;
            cmp_getx_valid <= 1'b0;
            cmp_getx_req   <= '0;
            cmp_getx_acks  <= '0;
        end else begin
            evt            <= hit ? cls_evt : '0;
            evt_idx        <= rsp_idx;
            err            <= accept && !sel_busy;
            cmp_valid      <= hit && cls_done;
            cmp_idx        <= rsp_idx;
            cmp_prefetch   <= sel_pf;
            cmp_gets_set   <= sel_gets;
            cmp_getx_valid <= sel_gxv;
            cmp_getx_req   <= sel_gxr;
            cmp_getx_acks  <= sel_gxa;
        end
    end
endmodule

// File: rtl/coh_trk_chk.sv
// Protocol checks on the tracker ports, bound to every tracker instance.
// Assumes: the caller holds rst_n low from time zero.
module coh_trk_chk
    import coh_trk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             alloc_gnt,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [EVT_W-1:0] evt,
    input logic             err,
    input logic             cmp_valid
);
    logic final_evt;
    assign final_evt = evt[EV_DATA_ZERO] || evt[EV_DATA_LAST] || evt[EV_ACK_LAST];

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_ready && evt == '0 && !err && !cmp_valid)); // R1
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> alloc_req); // R2
    AST_CMP_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        final_evt |-> cmp_valid); // R7
    AST_CMP_ONLY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> final_evt); // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (evt == '0 && !cmp_valid)); // R9
    AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt)); // R10
    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0 || err) |-> $past(rsp_valid && rsp_ready)); // R10
endmodule

bind coh_resp_tracker coh_trk_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .alloc_gnt (alloc_gnt),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .evt       (evt),
    .err       (err),
    .cmp_valid (cmp_valid)
);

// File: tb/coh_resp_tracker_tb.sv
`timescale 1ns/1ps
module coh_resp_tracker_tb_top;
    localparam int NE    = 4;
    localparam int NC    = 8;
    localparam int IDX_W = 2;
    localparam int REQ_W = 3;
    localparam int ACK_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 0, alloc_prefetch = 0;
    logic alloc_gnt;
    logic [IDX_W-1:0] alloc_idx;
    logic rsp_valid = 0, rsp_kind = 0;
    logic rsp_ready;
    logic [ACK_W-1:0] rsp_acks = '0;
    logic [IDX_W-1:0] rsp_idx = '0;
    logic fwd_gets_valid = 0, fwd_getx_valid = 0;
    logic [IDX_W-1:0] fwd_gets_idx = '0, fwd_getx_idx = '0;
    logic [REQ_W-1:0] fwd_gets_req = '0, fwd_getx_req = '0;
    logic [ACK_W-1:0] fwd_getx_acks = '0;
    logic [4:0] evt;
    logic [IDX_W-1:0] evt_idx, cmp_idx;
    logic err, cmp_valid, cmp_prefetch, cmp_getx_valid;
    logic [NC-1:0] cmp_gets_set;
    logic [REQ_W-1:0] cmp_getx_req;
    logic [ACK_W-1:0] cmp_getx_acks;

    always #10 clk = ~clk;

    coh_resp_tracker #(.NUM_ENTRIES(NE), .NUM_CACHES(NC)) dut_i (.*);

    int checks = 0;
    int errors = 0;

    // reference model of each record
    bit     m_busy [NE];
    int     m_cnt  [NE];
    bit     m_pf   [NE];
    bit [NC-1:0] m_gets [NE];
    bit     m_gxv  [NE];
    int     m_gxr  [NE];
    int     m_gxa  [NE];
    int     m_tot  [NE];
    bit     m_dsent[NE];
    int     m_asent[NE];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected event bit: 0 data zero, 1 data more, 2 data last, 3 ack, 4 last ack
    function automatic int exp_code(bit is_ack, int carried, int cnt);
        if (is_ack) return (cnt == 1) ? 4 : 3;
        if (carried == 0) return 0;
        if (carried + cnt == 0) return 2;
        return 1;
    endfunction

    function automatic int exp_lowest_free();
        for (int i = 0; i < NE; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    task automatic do_alloc(input bit pf, input int total);
        int exp_i;
        exp_i = exp_lowest_free();
        alloc_req = 1; alloc_prefetch = pf;
        #2;
        chk(alloc_gnt == (exp_i >= 0), "R2 alloc_gnt", alloc_gnt, exp_i >= 0);
        if (exp_i >= 0) chk(alloc_idx == IDX_W'(exp_i), "R2 alloc_idx", alloc_idx, exp_i);
        @(posedge clk);
        if (exp_i >= 0) begin
            m_busy[exp_i] = 1; m_cnt[exp_i] = 0; m_pf[exp_i] = pf; m_gets[exp_i] = '0;
            m_gxv[exp_i] = 0; m_gxr[exp_i] = 0; m_gxa[exp_i] = 0; m_tot[exp_i] = total;
            m_dsent[exp_i] = 0; m_asent[exp_i] = 0;
        end
        @(negedge clk);
        alloc_req = 0; alloc_prefetch = 0;
    endtask

    task automatic do_gets(input int idx, input int req);
        fwd_gets_valid = 1; fwd_gets_idx = IDX_W'(idx); fwd_gets_req = REQ_W'(req);
        @(posedge clk);
        if (m_busy[idx]) m_gets[idx][req] = 1'b1;
        @(negedge clk);
        fwd_gets_valid = 0;
    endtask

    task automatic do_getx(input int idx, input int req, input int acks);
        fwd_getx_valid = 1; fwd_getx_idx = IDX_W'(idx); fwd_getx_req = REQ_W'(req);
        fwd_getx_acks = ACK_W'(acks);
        @(posedge clk);
        if (m_busy[idx]) begin m_gxv[idx] = 1; m_gxr[idx] = req; m_gxa[idx] = acks; end
        @(negedge clk);
        fwd_getx_valid = 0;
    endtask

    task automatic do_rsp(input int idx, input bit is_ack, input int carried, input string tag);
        int code;
        bit done;
        chk(rsp_ready == 1'b1, {tag, " R10 ready"}, rsp_ready, 1);
        rsp_valid = 1; rsp_kind = is_ack; rsp_acks = ACK_W'(carried); rsp_idx = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 0;
        if (!m_busy[idx]) begin
            chk(err == 1'b1, {tag, " R9 err"}, err, 1);
            chk(evt == 5'd0, {tag, " R9 evt"}, evt, 0);
            chk(cmp_valid == 1'b0, {tag, " R9 cmp"}, cmp_valid, 0);
        end else begin
            code = exp_code(is_ack, carried, m_cnt[idx]);
            done = (code == 0 || code == 2 || code == 4);
            chk(evt == 5'(1 << code), {tag, " R10 evt"}, evt, 1 << code);
            chk(evt_idx == IDX_W'(idx), {tag, " R10 evt_idx"}, evt_idx, idx);
            chk(err == 1'b0, {tag, " R9 no err"}, err, 0);
            chk(cmp_valid == done, {tag, " R7 cmp_valid"}, cmp_valid, done);
            if (done) begin
                chk(cmp_idx == IDX_W'(idx), {tag, " R7 cmp_idx"}, cmp_idx, idx);
                chk(cmp_prefetch == m_pf[idx], {tag, " R7 prefetch"}, cmp_prefetch, m_pf[idx]);
                chk(cmp_gets_set == m_gets[idx], {tag, " R8 gets set"}, cmp_gets_set, m_gets[idx]);
                chk(cmp_getx_valid == m_gxv[idx], {tag, " R8 getx valid"}, cmp_getx_valid, m_gxv[idx]);
                if (m_gxv[idx]) begin
                    chk(cmp_getx_req == REQ_W'(m_gxr[idx]), {tag, " R8 getx req"}, cmp_getx_req, m_gxr[idx]);
                    chk(cmp_getx_acks == ACK_W'(m_gxa[idx]), {tag, " R8 getx acks"}, cmp_getx_acks, m_gxa[idx]);
                end
                m_busy[idx] = 0;
            end else if (is_ack) begin
                m_cnt[idx] = m_cnt[idx] - 1;
            end else begin
                m_cnt[idx] = m_cnt[idx] + carried;
            end
            if (is_ack) m_asent[idx]++; else m_dsent[idx] = 1;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0F));
        for (int i = 0; i < NE; i++) m_busy[i] = 0;
        repeat (3) @(negedge clk);
        chk(rsp_ready == 1'b0, "R1 ready in reset", rsp_ready, 0);
        chk(evt == 5'd0 && !err && !cmp_valid, "R1 outputs in reset", evt, 0);
        rst_n = 1;
        @(negedge clk);

        // directed: fill the table, then overflow
        do_alloc(1, 0);          // idx 0
        do_alloc(0, 3);          // idx 1
        do_alloc(0, 1);          // idx 2
        do_alloc(1, 2);          // idx 3
        do_alloc(0, 0);          // none free
        // R3: data with zero acks, prefetch flag reported
        do_rsp(0, 0, 0, "R3 data zero");
        // R6 acks before data, count negative; R4 data more; R6 last ack
        do_rsp(1, 1, 0, "R6 early ack");
        do_rsp(1, 1, 0, "R6 early ack 2");
        do_rsp(1, 0, 3, "R4 data more");
        do_rsp(1, 1, 0, "R6 last ack");
        // R8 forwards, then R5 data last after early ack
        do_gets(2, 2);
        do_gets(2, 5);
        do_getx(2, 6, 3);
        do_rsp(2, 1, 0, "R6 ack neg");
        do_rsp(2, 0, 1, "R5 data last");
        // R9 reply to a freed record, R8 forward to a free record dropped
        do_rsp(0, 0, 2, "R9 free record");
        do_gets(0, 1);
        do_alloc(0, 0);          // R2/R7 lowest free is 0, fresh state
        do_rsp(0, 0, 0, "R7 fresh record");
        // R4 then two acks
        do_rsp(3, 0, 2, "R4 data first");
        do_rsp(3, 1, 0, "R6 plain ack");
        do_rsp(3, 1, 0, "R6 final ack");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            int idx;
            op  = $urandom_range(0, 9);
            idx = $urandom_range(0, NE - 1);
            if (op < 2) begin
                do_alloc(1'($urandom_range(0, 1)), $urandom_range(0, NC));
            end else if (op == 2) begin
                if (m_busy[idx]) do_gets(idx, $urandom_range(0, NC - 1));
            end else if (op == 3) begin
                if (m_busy[idx]) do_getx(idx, $urandom_range(0, NC - 1), $urandom_range(0, NC));
            end else if (!m_busy[idx]) begin
                do_rsp(idx, 0, $urandom_range(0, NC), "R9 random free");
            end else if (!m_dsent[idx] && (m_asent[idx] == m_tot[idx] || $urandom_range(0, 1) == 1)) begin
                do_rsp(idx, 0, m_tot[idx], "R3 R4 R5 random data");
            end else begin
                do_rsp(idx, 1, 0, "R6 random ack");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule